// File: doc/BRIEF.md
# Basic-Block Control-Flow Monitor

This block runs beside an application core and checks, one basic block at a time, that the core follows the control-flow graph it was compiled for. Before the program starts, software loads a small table through the table port. Each entry describes one basic block: the exact number of instructions it retires, and up to `SUCC_N` block identifiers that may follow it. A mask marks which of those successor slots are in use.

While the program runs, the core announces every block it enters on the check-in port. The monitor does not rely on the core to report its own instruction count. It samples the core's free-running retired-instruction counter (`icount`) at every check-in. It also watches that counter in the cycles between check-ins. If a block retires a different number of instructions than the table says, the monitor raises the alarm. It does the same if a transition is not an allowed edge, or if instructions keep retiring past a block's length with no check-in. The alarm stays set until reset and carries a reason code.

Both input interfaces use valid/ready. The check-in port never applies back-pressure, so the core is never stalled. The table port accepts entries only until the first check-in. After that, `ld_ready` stays low until reset and the table is locked.

Top module: `bb_flow_guard`

## Requirements
- R1: After reset, `alarm` is 0, `alarm_code` is 0, `ld_ready` is 1 and `ci_ready` is 1.
- R2: When `ld_valid` and `ld_ready` are both high at a clock edge, entry `ld_id` is written. The entry takes `ld_count` as its length, slot i of `ld_succ` (bits `[i*ID_W +: ID_W]`) as successor i, and bit i of `ld_mask` as the enable for that slot. After the first check-in, `ld_ready` is 0 and loads have no effect until reset.
- R3: The first check-in after reset must name block `ENTRY_ID`. Any other identifier sets the alarm with code 2 (illegal edge).
- R4: At each later check-in, the monitor computes `icount` minus its value at the previous check-in, modulo 2^`PROBE_W`. If this differs from the stored length of the previous block, the alarm is set with code 1 (count mismatch).
- R5: At each later check-in, the new identifier must equal a successor slot of the previous block whose mask bit is 1. Otherwise the alarm is set with code 2. A slot whose mask bit is 0 never matches.
- R6: If one check-in has both a count mismatch and an illegal edge, the code is 1.
- R7: In a cycle with no check-in, the alarm is set with code 3 (missing check-in) if the count since the last check-in exceeds the stored length of the current block.
- R8: A fault sampled at one clock edge shows on `alarm`/`alarm_code` right after that edge. From then on, both hold their values until reset, whatever the inputs do.
- R9: `ci_ready` is always 1 outside reset, so check-ins are never refused.
- R10: The count difference is correct when `icount` wraps past 2^`PROBE_W`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Table entry offered |
| ld_ready | output | 1 | Table accepts entries (high until first check-in) |
| ld_id | input | ID_W | Block identifier being written |
| ld_count | input | CNT_W | Exact instruction count of the block |
| ld_succ | input | SUCC_N*ID_W | Successor identifiers, slot i at bits [i*ID_W +: ID_W] |
| ld_mask | input | SUCC_N | Enable for each successor slot |
| ci_valid | input | 1 | Core checks in to a block this cycle |
| ci_ready | output | 1 | Check-in accepted (always high) |
| ci_id | input | ID_W | Identifier of the block being entered |
| icount | input | PROBE_W | Core's retired-instruction counter (free-running, wraps) |
| alarm | output | 1 | Sticky attack alarm |
| alarm_code | output | 2 | 0 none, 1 count mismatch, 2 illegal edge, 3 missing check-in |

## Verification
Each scenario starts from reset with the same four-block table. Between scenarios, the core's path and its instruction counts change. A legal loop through several blocks shows that correct counts and allowed edges raise nothing. Runs that differ from it by one fault each tell the codes apart: a wrong entry block, a block that is one instruction short, a jump to an unlisted block, and a core that goes silent. Further runs target the corners: a count that is wrong together with an edge that is wrong (to check priority), a successor stored in a masked-off slot, a counter that wraps inside a block, and a table write attempted after the program has started.

// File: rtl/bbg_pkg.sv
package bbg_pkg;
  typedef enum logic [1:0] {
    ALM_NONE   = 2'd0,
    ALM_COUNT  = 2'd1,
    ALM_EDGE   = 2'd2,
    ALM_SILENT = 2'd3
  } alarm_e;
endpackage

// File: rtl/bb_table.sv
// Per-block descriptor storage: length, successor slots, slot enables.
module bb_table #(
  parameter int NUM_BLK = 16,
  parameter int ID_W    = 4,
  parameter int CNT_W   = 8,
  parameter int SUCC_N  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ID_W-1:0]          wid,
  input  logic [CNT_W-1:0]         wcnt,
  input  logic [SUCC_N*ID_W-1:0]   wsucc,
  input  logic [SUCC_N-1:0]        wmask,
  input  logic [ID_W-1:0]          rid,
  output logic [CNT_W-1:0]         rcnt,
  output logic [SUCC_N*ID_W-1:0]   rsucc,
  output logic [SUCC_N-1:0]        rmask
);
  logic [CNT_W-1:0]       len_q  [NUM_BLK];
  logic [SUCC_N*ID_W-1:0] succ_q [NUM_BLK];
  logic [SUCC_N-1:0]      mask_q [NUM_BLK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BLK; b++) begin
        len_q[b]  <= '0;
        succ_q[b] <= '0;
        mask_q[b] <= '0;
      end
    end else if (we) begin
      len_q[wid]  <= wcnt;
      succ_q[wid] <= wsucc;
      mask_q[wid] <= wmask;
    end
  end

  assign rcnt  = len_q[rid];
  assign rsucc = succ_q[rid];
  assign rmask = mask_q[rid];
endmodule

// File: rtl/bb_edge_check.sv
// Compares a candidate block id against every enabled successor slot.
module bb_edge_check #(
  parameter int ID_W   = 4,
  parameter int SUCC_N = 2
) (
  input  logic [SUCC_N*ID_W-1:0] succ,
  input  logic [SUCC_N-1:0]      mask,
  input  logic [ID_W-1:0]        cand,
  output logic                   hit
);
  logic [SUCC_N-1:0] slot_hit;

  for (genvar s = 0; s < SUCC_N; s++) begin : g_slot
    assign slot_hit[s] = mask[s] && (succ[s*ID_W +: ID_W] == cand);
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/bb_flow_guard.sv
module bb_flow_guard
  import bbg_pkg::*;
#(
  parameter int NUM_BLK  = 16,
  parameter int SUCC_N   = 2,
  parameter int CNT_W    = 8,
  parameter int PROBE_W  = 16,
  parameter int ENTRY_ID = 0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ld_valid,
  output logic                              ld_ready,
  input  logic [$clog2(NUM_BLK)-1:0]        ld_id,
  input  logic [CNT_W-1:0]                  ld_count,
  input  logic [SUCC_N*$clog2(NUM_BLK)-1:0] ld_succ,
  input  logic [SUCC_N-1:0]                 ld_mask,
  input  logic                              ci_valid,
  output logic                              ci_ready,
  input  logic [$clog2(NUM_BLK)-1:0]        ci_id,
  input  logic [PROBE_W-1:0]                icount,
  output logic                              alarm,
  output logic [1:0]                        alarm_code
);
  localparam int ID_W = $clog2(NUM_BLK);

  logic              started_q;
  logic              alarm_q;
  alarm_e            code_q;
  logic [ID_W-1:0]   cur_q;
  logic [PROBE_W-1:0] base_q;

  logic [CNT_W-1:0]       cur_len;
  logic [SUCC_N*ID_W-1:0] cur_succ;
  logic [SUCC_N-1:0]      cur_mask;
  logic                   edge_ok;
  logic [PROBE_W-1:0]     span;
  logic [PROBE_W-1:0]     len_ext;
  logic                   fault;
  alarm_e                 fault_code;

  assign ld_ready = rst_n && !started_q;
  assign ci_ready = rst_n;

  bb_table #(
    .NUM_BLK(NUM_BLK), .ID_W(ID_W), .CNT_W(CNT_W), .SUCC_N(SUCC_N)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .we(ld_valid && ld_ready),
    .wid(ld_id), .wcnt(ld_count), .wsucc(ld_succ), .wmask(ld_mask),
    .rid(cur_q),
    .rcnt(cur_len), .rsucc(cur_succ), .rmask(cur_mask)
  );

  bb_edge_check #(.ID_W(ID_W), .SUCC_N(SUCC_N)) u_edge (
    .succ(cur_succ), .mask(cur_mask), .cand(ci_id), .hit(edge_ok)
  );

  assign span    = icount - base_q;
  assign len_ext = PROBE_W'(cur_len);

  always_comb begin
    fault      = 1'b0;
    fault_code = ALM_NONE;
    if (ci_valid) begin
      if (!started_q) begin
        if (ci_id != ID_W'(ENTRY_ID)) begin
          fault      = 1'b1;
          fault_code = ALM_EDGE;
        end
      end else if (span != len_ext) begin
        fault      = 1'b1;
        fault_code = ALM_COUNT;
      end else if (!edge_ok) begin
        fault      = 1'b1;
        fault_code = ALM_EDGE;
      end
    end else if (started_q && (span > len_ext)) begin
      fault      = 1'b1;
      fault_code = ALM_SILENT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      alarm_q   <= 1'b0;
      code_q    <= ALM_NONE;
      cur_q     <= '0;
      base_q    <= '0;
    end else begin
      if (ci_valid) begin
        started_q <= 1'b1;
        cur_q     <= ci_id;
        base_q    <= icount;
      end
      if (!alarm_q && fault) begin
        alarm_q <= 1'b1;
        code_q  <= fault_code;
      end
    end
  end

  assign alarm      = alarm_q;
  assign alarm_code = code_q;

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> alarm);

  p_code_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> $stable(alarm_code));

  p_code_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> (alarm_code != 2'd0));

  p_table_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ci_valid |=> !ld_ready);

  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ci_valid |-> ci_ready);
endmodule

// File: tb/sim_bb_flow_guard.sv
`timescale 1ns/1ps
module sim_bb_flow_guard;
  localparam int NB = 16, SN = 2, CW = 8, PW = 16, IW = 4, ENTRY = 0;

  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, ci_valid = 0;
  logic ld_ready, ci_ready, alarm;
  logic [IW-1:0] ld_id = 0, ci_id = 0;
  logic [CW-1:0] ld_count = 0;
  logic [SN*IW-1:0] ld_succ = 0;
  logic [SN-1:0] ld_mask = 0;
  logic [PW-1:0] icount = 0;
  logic [1:0] alarm_code;

  int vectors = 0, errors = 0, cycles = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  bb_flow_guard #(.NUM_BLK(NB), .SUCC_N(SN), .CNT_W(CW), .PROBE_W(PW), .ENTRY_ID(ENTRY)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_id(ld_id),
    .ld_count(ld_count), .ld_succ(ld_succ), .ld_mask(ld_mask), .ci_valid(ci_valid),
    .ci_ready(ci_ready), .ci_id(ci_id), .icount(icount), .alarm(alarm), .alarm_code(alarm_code));

  // behavioural reference model
  int m_len [NB];
  int m_succ [NB][SN];
  bit m_en [NB][SN];
  bit m_started, m_alarm;
  int m_code, m_cur, m_base;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_started = 0; m_alarm = 0; m_code = 0; m_cur = 0; m_base = 0;
      for (int b = 0; b < NB; b++) begin
        m_len[b] = 0;
        for (int s = 0; s < SN; s++) begin m_succ[b][s] = 0; m_en[b][s] = 0; end
      end
    end else begin
      int span, f;
      bit ok;
      span = (int'(icount) - m_base) & ((1 << PW) - 1);
      f = 0;
      if (ci_valid) begin
        if (!m_started) f = (int'(ci_id) != ENTRY) ? 2 : 0;
        else begin
          ok = 0;
          for (int s = 0; s < SN; s++) if (m_en[m_cur][s] && m_succ[m_cur][s] == int'(ci_id)) ok = 1;
          if (span != m_len[m_cur]) f = 1;
          else if (!ok) f = 2;
        end
      end else if (m_started && span > m_len[m_cur]) f = 3;
      if (!m_alarm && f != 0) begin m_alarm = 1; m_code = f; end
      if (!m_started && ld_valid) begin
        m_len[ld_id] = ld_count;
        for (int s = 0; s < SN; s++) begin
          m_succ[ld_id][s] = ld_succ[s*IW +: IW];
          m_en[ld_id][s] = ld_mask[s];
        end
      end
      if (ci_valid) begin m_started = 1; m_cur = ci_id; m_base = icount; end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (alarm !== m_alarm || alarm_code !== 2'(m_code) || ld_ready !== !m_started || ci_ready !== 1'b1) begin
        errors++;
        $display("FAIL %s: alarm=%0b code=%0d ld_ready=%0b ci_ready=%0b expected alarm=%0b code=%0d ld_ready=%0b ci_ready=1",
                 tag, alarm, alarm_code, ld_ready, ci_ready, m_alarm, m_code, !m_started);
      end
    end
  end

  task automatic expect_code(input string t, input int code);
    vectors++;
    if (alarm !== (code != 0) || alarm_code !== 2'(code)) begin
      errors++;
      $display("FAIL %s: alarm=%0b code=%0d expected alarm=%0b code=%0d", t, alarm, alarm_code, code != 0, code);
    end
  endtask

  task automatic cyc(input bit v, input int id, input int adv);
    @(negedge clk);
    ci_valid = v; ci_id = IW'(id); icount = icount + PW'(adv);
    ld_valid = 0;
  endtask

  task automatic load(input int id, input int len, input int s0, input int s1, input int msk);
    @(negedge clk);
    ci_valid = 0; ld_valid = 1; ld_id = IW'(id); ld_count = CW'(len);
    ld_succ = {IW'(s1), IW'(s0)}; ld_mask = SN'(msk);
  endtask

  task automatic restart(input int ic);
    @(negedge clk);
    rst_n = 0; ci_valid = 0; ld_valid = 0; icount = PW'(ic);
    @(negedge clk);
    rst_n = 1;
    load(0, 3, 1, 2, 3);
    load(1, 2, 2, 3, 1);   // slot 1 (id 3) masked off
    load(2, 4, 0, 1, 3);
    load(3, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (200) begin
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: cycles=%0d expected <= 100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
      #5000;
    end
  end

  initial begin
    // R1 reset state
    tag = "R1"; restart(10);
    @(negedge clk); ld_valid = 0;
    vectors++;
    if (ld_ready !== 1 || ci_ready !== 1 || alarm !== 0 || alarm_code !== 0) begin
      errors++;
      $display("FAIL R1: ld_ready=%0b ci_ready=%0b alarm=%0b code=%0d expected 1 1 0 0", ld_ready, ci_ready, alarm, alarm_code);
    end

    // R4 R5 R9 legal loop 0->1->2->0->2
    tag = "R5";
    cyc(1, 0, 0); cyc(0, 0, 1); cyc(0, 0, 1); cyc(1, 1, 1);
    cyc(0, 0, 1); cyc(1, 2, 1);
    cyc(0, 0, 2); cyc(1, 0, 2);
    cyc(0, 0, 3); cyc(1, 2, 0);
    cyc(0, 0, 0); expect_code("R4 legal loop", 0);

    // R3 wrong entry block
    tag = "R3"; restart(5);
    cyc(1, 1, 0); cyc(0, 0, 0); expect_code("R3 bad entry", 2);

    // R4 block 0 one instruction short
    tag = "R4"; restart(5);
    cyc(1, 0, 0); cyc(0, 0, 1); cyc(1, 1, 1); cyc(0, 0, 0); expect_code("R4 short block", 1);

    // R5 jump to unlisted block 3
    tag = "R5"; restart(5);
    cyc(1, 0, 0); cyc(1, 3, 3); cyc(0, 0, 0); expect_code("R5 bad edge", 2);

    // R5 masked-off slot: 1 -> 3 stored but disabled
    restart(5);
    cyc(1, 0, 0); cyc(1, 1, 3); cyc(1, 3, 2); cyc(0, 0, 0); expect_code("R5 masked slot", 2);

    // R6 both faults at one check-in
    tag = "R6"; restart(5);
    cyc(1, 0, 0); cyc(1, 3, 2); cyc(0, 0, 0); expect_code("R6 priority", 1);

    // R7 silent core, then R8 sticky through later faults
    tag = "R7"; restart(5);
    cyc(1, 0, 0); cyc(0, 0, 3); cyc(0, 0, 0); expect_code("R7 at limit", 0);
    cyc(0, 0, 1); cyc(0, 0, 0); expect_code("R7 silent", 3);
    tag = "R8";
    cyc(1, 3, 5); cyc(1, 1, 0); cyc(0, 0, 9); cyc(0, 0, 0); expect_code("R8 sticky", 3);

    // R10 counter wrap inside block 0
    tag = "R10"; restart(16'hFFFE);
    cyc(1, 0, 0); cyc(0, 0, 1); cyc(0, 0, 1); cyc(1, 2, 1); cyc(0, 0, 0); expect_code("R10 wrap", 0);

    // R2 load after start ignored (would make block 0 length 5)
    tag = "R2"; restart(5);
    cyc(1, 0, 0);
    load(0, 5, 1, 2, 3);
    cyc(0, 0, 3); cyc(1, 1, 0); cyc(0, 0, 0); expect_code("R2 locked table", 0);
    vectors++;
    if (ld_ready !== 0) begin
      errors++; $display("FAIL R2: ld_ready=%0b expected 0", ld_ready);
    end

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule